// File: doc/BRIEF.md
# Hibernate Power-Mode Sequencer

This block runs in the always-on domain and takes the chip into and out of its deepest low-power mode. Software first selects hibernate in a mode field. When the processor then issues its idle request with the clock multiplier bypassed, the block moves through four steps. It freezes the I/O pads through isolation, keeps the retention memory banks powered, and then removes power from the switchable logic. It brings the logic back through a reset.

While the logic is gated, two inputs end hibernate: an asynchronous wake pin and the external reset pin. Each is synchronised to the always-on clock. The block then restores power and holds the core reset for a fixed count of cycles. It also records a wake-cause flag, so boot code can tell a hibernate wake from a cold start and leave the retention banks untouched. Pad isolation and any error captured during entry stay latched across that reset. Software releases them by writing a 1 to a release bit, and a boot-completion pulse releases them if software never does.

Top module: `hib_seq`

## Requirements
- R1: After power-on reset the switchable logic is powered, isolation and the error pin are low, the retention enables are low, and both registers read 0.
- R2: An idle request starts entry only when the mode field (control register at address 0, bits [1:0]) holds 2'b10; any other value leaves the block running.
- R3: An idle request with hibernate selected while `pll_bypassed` is low does not enter. It sets the violation flag at status bit 3 (status register at address 1), and writing a 1 to that bit clears it.
- R4: Entry asserts isolation for exactly one cycle while power is still on. Power then drops with isolation high, every retention enable high and the core reset asserted.
- R5: The wake pin passes through SYNC_STAGES flops, and a high synchronised level during the gated state starts the wake reset. The wake pin has no effect while running.
- R6: A low level on the external reset pin during the gated state also starts the wake reset.
- R7: The wake reset restores power at once and holds `core_rst_n` low for exactly RST_CYC cycles, then returns to running. The mode field reads 0 afterwards. A simultaneous wake-pin and reset-pin event gives one such reset.
- R8: Every hibernate wake sets the wake-cause flag at status bit 0. The flag survives the wake reset and clears when a 1 is written to it.
- R9: Isolation (readable at status bit 1) stays high after the wake until a 1 is written to control bit 2 while running. If that write falls in the same cycle as an accepted entry, the entry wins and isolation stays set.
- R10: A `boot_done` pulse while running releases isolation as a fallback.
- R11: An error event in the cycle an entry is accepted, or in the isolate cycle, sets the error pin (status bit 2). The pin holds until isolation is released. Error events at other times are ignored.
- R12: Register writes are ignored while the block is not running.
- R13: While running, `core_rst_n` follows the synchronised external reset pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset of the always-on domain, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| idle_req | input | 1 | Idle request from the processor |
| pll_bypassed | input | 1 | Clock multiplier is in bypass |
| err_evt | input | 1 | Error event |
| boot_done | input | 1 | Boot firmware finished, fallback isolation release |
| wake_pin | input | 1 | Asynchronous wake input, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| core_pwr_en | output | 1 | Supply enable of the switchable logic |
| ret_en | output | N_RET | Retention bank supply enables |
| iso_en | output | 1 | Pad isolation |
| err_pin | output | 1 | Latched error status |
| core_rst_n | output | 1 | Reset to the switchable logic, active low |

## Verification
Two pairs of events can land in the same cycle. The first is a release write and an accepted entry. The bench issues one control write that selects hibernate and sets the release bit, and pulses the idle request on that same cycle. It then expects isolation to stay high and power to drop one cycle later. The second is a wake from both sources at once. Here the bench raises the wake pin and pulls the reset pin low on the same edge, and judges the result by counting exactly RST_CYC cycles of core reset before it releases.

// File: rtl/hib_pkg.sv
package hib_pkg;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_ISOLATE  = 2'd1,
      ST_GATED    = 2'd2,
      ST_WAKE_RST = 2'd3
   } hib_state_e;

   localparam logic [1:0] MODE_HIB = 2'b10;

   localparam int CTRL_ADDR = 0;
   localparam int STAT_ADDR = 1;

   localparam int CTRL_REL_BIT   = 2;
   localparam int STAT_WAKE_BIT  = 0;
   localparam int STAT_ISO_BIT   = 1;
   localparam int STAT_ERR_BIT   = 2;
   localparam int STAT_VIOL_BIT  = 3;

endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hib_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
   import hib_pkg::*;
#(
   parameter int RST_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enter,
   input  logic       wake,
   output hib_state_e state,
   output logic       wake_evt
);
   localparam int CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;

   if (RST_CYC < 2) begin : g_bad_cyc
      $error("hib_fsm: RST_CYC must be at least 2");
   end

   hib_state_e       st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RUN;
         cnt <= '0;
      end else begin
         case (st)
            ST_RUN:      if (enter) st <= ST_ISOLATE;
            ST_ISOLATE:  st <= ST_GATED;
            ST_GATED:    if (wake) begin
                            st  <= ST_WAKE_RST;
                            cnt <= CNT_W'(RST_CYC - 1);
                         end
            ST_WAKE_RST: if (cnt == '0) st <= ST_RUN;
                         else           cnt <= cnt - 1'b1;
            default:     st <= ST_RUN;
         endcase
      end
   end

   assign state    = st;
   assign wake_evt = (st == ST_GATED) && wake;
endmodule

// File: rtl/hib_regs.sv
module hib_regs
   import hib_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int ADDR_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic              isolating,
   input  logic              wake_evt,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              idle_req,
   input  logic              pll_bypassed,
   input  logic              err_evt,
   input  logic              boot_done,
   output logic              enter,
   output logic              iso_q,
   output logic              err_q
);
   if (DATA_W < 4) begin : g_bad_dw
      $error("hib_regs: DATA_W must be at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("hib_regs: ADDR_W must be at least 1");
   end

   logic [1:0] mode_q;
   logic       wake_q, viol_q;
   logic       attempt, wr_ctrl, wr_stat, release_iso;

   assign attempt     = running && idle_req && (mode_q == MODE_HIB);
   assign enter       = attempt && pll_bypassed;
   assign wr_ctrl     = running && bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign wr_stat     = running && bus_we && (bus_addr == ADDR_W'(STAT_ADDR));
   assign release_iso = running && ((wr_ctrl && bus_wdata[CTRL_REL_BIT]) || boot_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         iso_q  <= 1'b0;
         err_q  <= 1'b0;
         wake_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         if (wake_evt)     mode_q <= '0;
         else if (wr_ctrl) mode_q <= bus_wdata[1:0];

         if (enter)            iso_q <= 1'b1;
         else if (release_iso) iso_q <= 1'b0;

         if ((enter || isolating) && err_evt) err_q <= 1'b1;
         else if (release_iso && !enter)      err_q <= 1'b0;

         if (wake_evt)                                wake_q <= 1'b1;
         else if (wr_stat && bus_wdata[STAT_WAKE_BIT]) wake_q <= 1'b0;

         if (attempt && !pll_bypassed)                 viol_q <= 1'b1;
         else if (wr_stat && bus_wdata[STAT_VIOL_BIT]) viol_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[1:0] = mode_q;
      end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
         bus_rdata[STAT_WAKE_BIT] = wake_q;
         bus_rdata[STAT_ISO_BIT]  = iso_q;
         bus_rdata[STAT_ERR_BIT]  = err_q;
         bus_rdata[STAT_VIOL_BIT] = viol_q;
      end
   end
endmodule

// File: rtl/hib_seq.sv
module hib_seq
   import hib_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int ADDR_W      = 1,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 16,
   parameter int N_RET       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              idle_req,
   input  logic              pll_bypassed,
   input  logic              err_evt,
   input  logic              boot_done,
   input  logic              wake_pin,
   input  logic              ext_rst_n,
   output logic              core_pwr_en,
   output logic [N_RET-1:0]  ret_en,
   output logic              iso_en,
   output logic              err_pin,
   output logic              core_rst_n
);
   if (N_RET < 1) begin : g_bad_ret
      $error("hib_seq: N_RET must be at least 1");
   end

   hib_state_e state;
   logic       wake_s, ext_s, enter, wake_evt, iso_q, err_q;

   hib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
      .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(wake_s));

   hib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_xrst_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(ext_s));

   hib_fsm #(.RST_CYC(RST_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enter(enter),
      .wake(wake_s || !ext_s), .state(state), .wake_evt(wake_evt));

   hib_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .running(state == ST_RUN), .isolating(state == ST_ISOLATE),
      .wake_evt(wake_evt),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .idle_req(idle_req), .pll_bypassed(pll_bypassed), .err_evt(err_evt),
      .boot_done(boot_done), .enter(enter), .iso_q(iso_q), .err_q(err_q));

   for (genvar b = 0; b < N_RET; b++) begin : g_ret
      assign ret_en[b] = (state != ST_RUN);
   end

   assign core_pwr_en = (state != ST_GATED);
   assign iso_en      = iso_q;
   assign err_pin     = err_q;
   assign core_rst_n  = (state == ST_RUN) && ext_s;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
   parameter int N_RET = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic             boot_done,
   input logic             pll_bypassed,
   input logic             core_pwr_en,
   input logic [N_RET-1:0] ret_en,
   input logic             iso_en,
   input logic             err_pin,
   input logic             core_rst_n
);
   a_r4_iso_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_pwr_en) |-> $past(iso_en));

   a_r4_gated_safe: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> (iso_en && (&ret_en) && !core_rst_n));

   a_r7_power_up_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pwr_en) |-> !core_rst_n);

   a_r3_entry_needs_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_en) |-> $past(pll_bypassed));

   a_r9_iso_held: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_en && !bus_we && !boot_done) |=> iso_en);

   a_r11_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pin && iso_en) |=> (err_pin || !iso_en));

   a_r11_err_needs_iso: assert property (@(posedge clk) disable iff (!rst_n)
      err_pin |-> iso_en);
endmodule

bind hib_seq hib_seq_chk #(.N_RET(N_RET)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .boot_done(boot_done),
   .pll_bypassed(pll_bypassed), .core_pwr_en(core_pwr_en), .ret_en(ret_en),
   .iso_en(iso_en), .err_pin(err_pin), .core_rst_n(core_rst_n));

// File: tb/hib_seq_test.sv
module hib_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC    = 16;
   localparam int N_RET      = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [0:0] bus_addr = '0;
   logic [3:0] bus_wdata = '0;
   logic [3:0] bus_rdata;
   logic       idle_req = 1'b0, pll_bypassed = 1'b1, err_evt = 1'b0;
   logic       boot_done = 1'b0, wake_pin = 1'b0, ext_rst_n = 1'b1;
   logic       core_pwr_en, iso_en, err_pin, core_rst_n;
   logic [N_RET-1:0] ret_en;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   typedef struct { string tag; int val; } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hib_seq #(.DATA_W(4), .ADDR_W(1), .SYNC_STAGES(2), .RST_CYC(RST_CYC), .N_RET(N_RET)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_req(idle_req),
      .pll_bypassed(pll_bypassed), .err_evt(err_evt), .boot_done(boot_done),
      .wake_pin(wake_pin), .ext_rst_n(ext_rst_n), .core_pwr_en(core_pwr_en),
      .ret_en(ret_en), .iso_en(iso_en), .err_pin(err_pin), .core_rst_n(core_rst_n));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side: queue the expected value
   task automatic expect_v(input string tag, input int val);
      sb.push_back('{tag, val});
   endtask

   // monitor side: pop and compare against what the design shows
   task automatic observe(input int act);
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (act != e.val) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.val);
      end
   endtask

   task automatic chk(input string tag, input int exp_val, input int act);
      expect_v(tag, exp_val);
      observe(act);
   endtask

   task automatic wr(input int a, input int d);
      bus_we = 1'b1; bus_addr = 1'(a); bus_wdata = 4'(d);
      tick(1);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output int d);
      bus_addr = 1'(a);
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic idle_pulse();
      idle_req = 1'b1;
      tick(1);
      idle_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      tick(3);
      rst_n = 1'b1;
      tick(3);
      // R1 reset state
      chk("R1 pwr", 1, int'(core_pwr_en));
      chk("R1 iso", 0, int'(iso_en));
      chk("R1 err", 0, int'(err_pin));
      chk("R1 ret", 0, int'(ret_en));
      rd(1, v); chk("R1 status", 0, v);
      rd(0, v); chk("R1 ctrl", 0, v);
      chk("R13 core reset released", 1, int'(core_rst_n));

      // R13 external reset while running
      ext_rst_n = 1'b0; tick(2);
      chk("R13 follows pin low", 0, int'(core_rst_n));
      ext_rst_n = 1'b1; tick(2);
      chk("R13 follows pin high", 1, int'(core_rst_n));

      // R5 wake pin ignored while running
      wake_pin = 1'b1; tick(4);
      chk("R5 run wake pwr", 1, int'(core_pwr_en));
      chk("R5 run wake reset", 1, int'(core_rst_n));
      rd(1, v); chk("R5 run wake no cause", 0, v);
      wake_pin = 1'b0; tick(3);

      // R2 mode not hibernate
      idle_pulse();
      chk("R2 no entry in mode 0", 0, int'(iso_en));
      tick(1);
      chk("R2 still powered", 1, int'(core_pwr_en));
      wr(0, 2);
      rd(0, v); chk("R2 mode readback", 2, v);

      // R3 multiplier not bypassed
      pll_bypassed = 1'b0;
      idle_pulse();
      chk("R3 entry blocked", 0, int'(iso_en));
      rd(1, v); chk("R3 violation flag", 8, v);
      wr(1, 8);
      rd(1, v); chk("R3 violation cleared", 0, v);
      pll_bypassed = 1'b1;

      // R4 entry sequence
      idle_pulse();
      chk("R4 isolate iso", 1, int'(iso_en));
      chk("R4 isolate pwr on", 1, int'(core_pwr_en));
      tick(1);
      chk("R4 gated pwr off", 0, int'(core_pwr_en));
      chk("R4 gated ret", 3, int'(ret_en));
      chk("R4 gated reset", 0, int'(core_rst_n));

      // R12 writes ignored while gated
      wr(0, 4);
      tick(2);
      chk("R12 release ignored", 1, int'(iso_en));
      chk("R12 still gated", 0, int'(core_pwr_en));

      // R5 / R7 wake via pin
      wake_pin = 1'b1; tick(3);
      chk("R5 wake pwr on", 1, int'(core_pwr_en));
      chk("R7 reset held", 0, int'(core_rst_n));
      wake_pin = 1'b0;
      tick(RST_CYC - 1);
      chk("R7 reset still held at end", 0, int'(core_rst_n));
      tick(1);
      chk("R7 reset released", 1, int'(core_rst_n));
      rd(1, v); chk("R8 R9 status after wake", 3, v);
      rd(0, v); chk("R7 mode cleared", 0, v);

      // R9 release, R8 clear cause
      wr(0, 4);
      chk("R9 iso released", 0, int'(iso_en));
      wr(1, 1);
      rd(1, v); chk("R8 cause cleared", 0, v);

      // R11 error outside flight ignored
      err_evt = 1'b1; tick(1); err_evt = 1'b0;
      chk("R11 stray error ignored", 0, int'(err_pin));

      // R11 error during entry, R6 wake via reset pin, R10 fallback
      wr(0, 2);
      idle_req = 1'b1; err_evt = 1'b1;
      tick(1);
      idle_req = 1'b0; err_evt = 1'b0;
      chk("R11 error latched", 1, int'(err_pin));
      tick(1);
      chk("R11 gated", 0, int'(core_pwr_en));
      ext_rst_n = 1'b0; tick(3);
      chk("R6 reset pin wakes", 1, int'(core_pwr_en));
      ext_rst_n = 1'b1;
      tick(RST_CYC);
      chk("R6 back to run", 1, int'(core_rst_n));
      chk("R11 error held through wake", 1, int'(err_pin));
      rd(1, v); chk("R6 R8 status", 7, v);
      boot_done = 1'b1; tick(1); boot_done = 1'b0;
      chk("R10 fallback iso", 0, int'(iso_en));
      chk("R11 error cleared with iso", 0, int'(err_pin));
      wr(1, 1);

      // collision: release write and entry in one cycle; dual wake
      wr(0, 2);
      idle_pulse();
      tick(1);
      wake_pin = 1'b1; tick(3); wake_pin = 1'b0;
      tick(RST_CYC);
      chk("R9 iso kept after wake", 1, int'(iso_en));
      wr(0, 2);
      wr(1, 1);
      bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 4'd6; idle_req = 1'b1;
      tick(1);
      bus_we = 1'b0; bus_wdata = '0; idle_req = 1'b0;
      chk("R9 entry beats release", 1, int'(iso_en));
      tick(1);
      chk("R9 gated after collision", 0, int'(core_pwr_en));
      wake_pin = 1'b1; ext_rst_n = 1'b0;
      tick(3);
      chk("R7 dual wake pwr", 1, int'(core_pwr_en));
      wake_pin = 1'b0; ext_rst_n = 1'b1;
      tick(RST_CYC - 1);
      chk("R7 dual wake held", 0, int'(core_rst_n));
      tick(1);
      chk("R7 dual wake single reset", 1, int'(core_rst_n));
      rd(1, v); chk("R8 dual wake cause", 3, v);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule